// File: doc/BRIEF.md
# Banked Status Register File

This block keeps a processor's live status word and five saved status words, one for each of the fast-interrupt, interrupt, supervisor, abort and undefined modes. The low five bits of the live word form the mode field. The mode field picks which saved word a saved-word access reaches. Several mode encodings that no mode defines are legal. Some of them alias onto an existing saved word, and some reach no saved word at all.

The block performs four operations. A write moves a value into the live word or the saved word through a byte-field mask; the value is a register operand or a rotated 8-bit immediate. A read returns the live word or the saved word. An exception return copies the selected saved word into the live word. Reset loads the fixed start values. Bit 4 is forced to one on every value written or restored, so the mode field always lies in 0x10 to 0x1F. All updates happen on the rising clock edge, and reads are combinational.

Top module: `psr_bank_top`

## Requirements
- R1: While reset is low, the live word is 0x000000D3 and every saved word is 0x00000010.
- R2: Any value written or restored has bit 4 set to one, whatever the operand holds.
- R3: fieldEn[0] enables bits 7:0, fieldEn[1] bits 15:8, fieldEn[2] bits 23:16 and fieldEn[3] bits 31:24. Bits in bytes that are not enabled keep their old value.
- R4: When wrUseImm is 1, the operand is immByte zero-extended to 32 bits and rotated right by twice immRot. When wrUseImm is 0, the operand is regVal.
- R5: Mode 0x11 selects saved word 0 (fast interrupt), 0x12 selects saved word 1 (interrupt) and 0x13 selects saved word 2 (supervisor).
- R6: Modes 0x14 to 0x17 all select the abort saved word, and modes 0x18 to 0x1B all select the undefined saved word.
- R7: In modes 0x10 and 0x1C to 0x1F, a saved-word read (rdSaved=1) returns the live word.
- R8: In modes 0x10 and 0x1C to 0x1F, a saved-word write changes no stored word.
- R9: retEn copies the selected saved word into the live word at the clock edge. In a mode with no saved word, retEn leaves the live word unchanged.
- R10: rdData and curMode reflect the state before the edge; a write becomes visible only after the edge.
- R11: When retEn and wrEn are both asserted, the return takes effect and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Perform a masked write this cycle |
| wrSaved | input | 1 | Write targets the saved word (1) or the live word (0) |
| wrUseImm | input | 1 | Operand is the rotated immediate (1) or regVal (0) |
| fieldEn | input | 4 | Byte enables of the write mask |
| regVal | input | 32 | Register operand |
| immByte | input | 8 | Immediate byte |
| immRot | input | 4 | Immediate rotate field (rotate right by twice this value) |
| retEn | input | 1 | Exception return: copy the saved word into the live word |
| rdSaved | input | 1 | Read selects the saved word (1) or the live word (0) |
| rdData | output | 32 | Read result |
| curPsr | output | 32 | Live status word |
| curMode | output | 5 | Mode field of the live word |

## Verification
The bench walks the live word through every mode class: the defined modes, the aliased abort and undefined encodings, and the modes with no saved word. In each mode it writes and reads saved words, so an alias mapped to the wrong bank shows up as a value appearing in, or missing from, a neighbouring mode. Operands with bit 4 clear and partial byte masks separate the forcing and masking logic from plain copying. Rotated immediates with non-zero rotate fields catch an off-by-two in the rotate amount. Every operation also samples the read port before its edge, which exposes any update that appears too early, and a cycle with both return and write asserted shows which of the two wins.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int DATA_W     = 32;
  localparam int MODE_W     = 5;
  localparam int NUM_BANKS  = 5;
  localparam int BANK_IDX_W = $clog2(NUM_BANKS);
  localparam int NUM_FIELDS = DATA_W / 8;

  localparam logic [DATA_W-1:0] RESET_CUR   = 32'h0000_00D3;
  localparam logic [DATA_W-1:0] RESET_SAVED = 32'h0000_0010;
  localparam logic [DATA_W-1:0] FORCE_BITS  = 32'h0000_0010;

  typedef enum logic [BANK_IDX_W-1:0] {
    BANK_FIQ = 3'd0,
    BANK_IRQ = 3'd1,
    BANK_SVC = 3'd2,
    BANK_ABT = 3'd3,
    BANK_UND = 3'd4
  } bankId_e;

  typedef struct packed {
    logic                  wrCur;
    logic [NUM_BANKS-1:0]  wrBank;
    logic                  restore;
    logic                  useImm;
    logic                  bankValid;
    bankId_e               bankIdx;
  } psrStrobe_t;

  function automatic logic [DATA_W-1:0] rotImm(input logic [7:0] b, input logic [3:0] r);
    logic [DATA_W-1:0] ext;
    logic [5:0]        amt;
    ext = {{(DATA_W-8){1'b0}}, b};
    amt = {1'b0, r, 1'b0};
    return (ext >> amt) | (ext << (6'd32 - amt));
  endfunction
endpackage

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSaved,
  input  logic              wrUseImm,
  input  logic              retEn,
  input  logic [MODE_W-1:0] curMode,
  output psrStrobe_t        strobe
);
  bankId_e bankIdx;
  logic    bankValid;
  logic    writeGo;

  always_comb begin
    bankValid = 1'b1;
    bankIdx   = BANK_FIQ;
    unique case (curMode[3:0])
      4'h1:                      bankIdx = BANK_FIQ;
      4'h2:                      bankIdx = BANK_IRQ;
      4'h3:                      bankIdx = BANK_SVC;
      4'h4, 4'h5, 4'h6, 4'h7:    bankIdx = BANK_ABT;
      4'h8, 4'h9, 4'hA, 4'hB:    bankIdx = BANK_UND;
      default:                   bankValid = 1'b0;
    endcase
  end

  assign writeGo = wrEn && !retEn;

  always_comb begin
    strobe           = '0;
    strobe.bankIdx   = bankIdx;
    strobe.bankValid = bankValid;
    strobe.useImm    = wrUseImm;
    strobe.restore   = retEn && bankValid;
    strobe.wrCur     = writeGo && !wrSaved;
    for (int i = 0; i < NUM_BANKS; i++)
      strobe.wrBank[i] = writeGo && wrSaved && bankValid && (int'(bankIdx) == i);
  end

  p_onehot_bank_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.wrBank));
  p_ret_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (retEn && wrEn) |-> (strobe.wrCur == 1'b0 && strobe.wrBank == '0));
  p_nobank_nowrite_r8: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 5'h10 || curMode[3:2] == 2'b11) |-> (strobe.wrBank == '0 && !strobe.restore));
endmodule

// File: rtl/psr_datapath.sv
module psr_datapath
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  psrStrobe_t        strobe,
  input  logic [NUM_FIELDS-1:0] fieldEn,
  input  logic [DATA_W-1:0] regVal,
  input  logic [7:0]        immByte,
  input  logic [3:0]        immRot,
  input  logic              rdSaved,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] curQ
);
  logic [DATA_W-1:0] savedQ [NUM_BANKS];
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] selSaved;

  assign operand = (strobe.useImm ? rotImm(immByte, immRot) : regVal) | FORCE_BITS;

  genvar f;
  generate
    for (f = 0; f < NUM_FIELDS; f++) begin : g_mask
      assign mask[f*8 +: 8] = {8{fieldEn[f]}};
    end
  endgenerate

  assign selSaved = savedQ[strobe.bankIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               curQ <= RESET_CUR;
    else if (strobe.restore) curQ <= selSaved | FORCE_BITS;
    else if (strobe.wrCur)   curQ <= (curQ & ~mask) | (operand & mask);
  end

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 savedQ[b] <= RESET_SAVED;
        else if (strobe.wrBank[b]) savedQ[b] <= (savedQ[b] & ~mask) | (operand & mask);
      end
      p_saved_bit4_r2: assert property (@(posedge clk) disable iff (!rstN) savedQ[b][4]);
    end
  endgenerate

  assign rdData = (rdSaved && strobe.bankValid) ? selSaved : curQ;

  p_cur_bit4_r2: assert property (@(posedge clk) disable iff (!rstN) curQ[4]);
  p_reset_val_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (curQ == RESET_CUR));
  p_restore_copy_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restore |=> (curQ == ($past(selSaved) | FORCE_BITS)));
  p_flags_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrCur && !strobe.restore && !fieldEn[NUM_FIELDS-1]) |=>
      $stable(curQ[DATA_W-1 -: 8]));
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrCur && !strobe.restore) |=> $stable(curQ));
endmodule

// File: rtl/psr_bank_top.sv
module psr_bank_top
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSaved,
  input  logic              wrUseImm,
  input  logic [3:0]        fieldEn,
  input  logic [31:0]       regVal,
  input  logic [7:0]        immByte,
  input  logic [3:0]        immRot,
  input  logic              retEn,
  input  logic              rdSaved,
  output logic [31:0]       rdData,
  output logic [31:0]       curPsr,
  output logic [4:0]        curMode
);
  psrStrobe_t strobe;

  assign curMode = curPsr[MODE_W-1:0];

  psr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSaved  (wrSaved),
    .wrUseImm (wrUseImm),
    .retEn    (retEn),
    .curMode  (curMode),
    .strobe   (strobe)
  );

  psr_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .fieldEn (fieldEn),
    .regVal  (regVal),
    .immByte (immByte),
    .immRot  (immRot),
    .rdSaved (rdSaved),
    .rdData  (rdData),
    .curQ    (curPsr)
  );
endmodule

// File: tb/tb_psr_bank_top.sv
module tb_psr_bank_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrSaved = 1'b0, wrUseImm = 1'b0, retEn = 1'b0, rdSaved = 1'b0;
  logic [3:0]  fieldEn = '0;
  logic [31:0] regVal = '0;
  logic [7:0]  immByte = '0;
  logic [3:0]  immRot = '0;
  logic [31:0] rdData, curPsr;
  logic [4:0]  curMode;

  always #2 clk = ~clk;

  psr_bank_top dut (.*);

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       q[$];
  event        sampleEv;
  int          total = 0;
  int          failed = 0;
  logic [31:0] mcur;
  logic [31:0] msav [5];
  bit          done = 0;

  function automatic int bankOf(logic [4:0] m);
    case (m[3:0])
      4'h1: return 0;
      4'h2: return 1;
      4'h3: return 2;
      4'h4, 4'h5, 4'h6, 4'h7: return 3;
      4'h8, 4'h9, 4'hA, 4'hB: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] modelRead(bit saved);
    int b = bankOf(mcur[4:0]);
    if (saved && b >= 0) return msav[b];
    return mcur;
  endfunction

  function automatic logic [31:0] modelRot(logic [7:0] v, logic [3:0] r);
    logic [31:0] x = {24'd0, v};
    for (int i = 0; i < 2 * int'(r); i++) x = {x[0], x[31:1]};
    return x;
  endfunction

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(sampleEv);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = (it.kind == 0) ? rdData : (it.kind == 1) ? curPsr : {27'd0, curMode};
        total++;
        if (act !== it.exp) begin
          failed++;
          $display("FAIL %s kind=%0d actual=%08h expected=%08h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic flush();
    ->sampleEv;
    wait (q.size() == 0);
  endtask

  // driver: one operation; also checks the pre-edge read (R10)
  task automatic doOp(bit we, bit ws, bit ui, logic [3:0] fe, logic [31:0] rv,
                      logic [7:0] ib, logic [3:0] ir, bit re);
    logic [31:0] val, msk;
    int b;
    @(negedge clk);
    wrEn = we; wrSaved = ws; wrUseImm = ui; fieldEn = fe; regVal = rv;
    immByte = ib; immRot = ir; retEn = re; rdSaved = 1'b1;
    #1;
    q.push_back('{0, modelRead(1), "R10"});
    q.push_back('{2, {27'd0, mcur[4:0]}, "R10"});
    flush();
    @(posedge clk);
    b = bankOf(mcur[4:0]);
    val = (ui ? modelRot(ib, ir) : rv) | 32'h10;
    for (int i = 0; i < 4; i++) msk[i*8 +: 8] = {8{fe[i]}};
    if (re) begin
      if (b >= 0) mcur = msav[b] | 32'h10;
    end else if (we) begin
      if (!ws) mcur = (mcur & ~msk) | (val & msk);
      else if (b >= 0) msav[b] = (msav[b] & ~msk) | (val & msk);
    end
    #1;
    wrEn = 0; retEn = 0; wrSaved = 0; wrUseImm = 0; fieldEn = '0;
  endtask

  task automatic check(bit saved, string tag);
    @(negedge clk);
    rdSaved = saved;
    #1;
    q.push_back('{0, modelRead(saved), tag});
    q.push_back('{1, mcur, tag});
    flush();
  endtask

  task automatic setMode(logic [4:0] m);
    doOp(1, 0, 1, 4'b0001, '0, {3'd0, m}, 4'd0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    mcur = 32'h0000_00D3;
    for (int i = 0; i < 5; i++) msav[i] = 32'h10;
    rdSaved = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    q.push_back('{1, 32'h0000_00D3, "R1"});
    q.push_back('{0, 32'h0000_0010, "R1"});
    flush();
    @(negedge clk); rstN = 1'b1;
    check(1, "R1");

    // R2: operand bit 4 clear is forced on, supervisor saved word
    doOp(1, 1, 0, 4'hF, 32'hAABB_CCE5, '0, '0, 0);
    check(1, "R2");
    // R3: flags-only write to the live word
    doOp(1, 0, 0, 4'b1000, 32'hF000_0000, '0, '0, 0);
    check(0, "R3");
    // R6: move into abort mode 0x17
    setMode(5'h17);
    check(1, "R6");
    // R4: rotated immediate into the abort saved word
    doOp(1, 1, 1, 4'hF, '0, 8'hAB, 4'd4, 0);
    check(1, "R4");
    doOp(1, 1, 1, 4'b0010, '0, 8'h3C, 4'd15, 0);
    check(1, "R4");
    setMode(5'h14);
    check(1, "R6");
    // R6: undefined aliases 0x1A and 0x1B, partial mask (R3)
    setMode(5'h1A);
    doOp(1, 1, 0, 4'b0011, 32'h1234_5608, '0, '0, 0);
    setMode(5'h1B);
    check(1, "R6");
    check(1, "R3");
    setMode(5'h18);
    check(1, "R6");
    // R5: fast interrupt and interrupt saved words
    setMode(5'h11);
    doOp(1, 1, 0, 4'hF, 32'h1111_1101, '0, '0, 0);
    check(1, "R5");
    setMode(5'h12);
    doOp(1, 1, 0, 4'hF, 32'h2222_2202, '0, '0, 0);
    check(1, "R5");
    doOp(1, 1, 0, 4'b0100, 32'h00EE_0000, '0, '0, 0);
    check(1, "R3");
    setMode(5'h11);
    check(1, "R5");
    // R7 / R8: modes with no saved word
    setMode(5'h1F);
    check(1, "R7");
    doOp(1, 1, 0, 4'hF, 32'hDEAD_BEEF, '0, '0, 0);
    check(1, "R8");
    setMode(5'h10);
    check(1, "R7");
    doOp(1, 1, 0, 4'hF, 32'hCAFE_F00D, '0, '0, 0);
    setMode(5'h1C);
    check(1, "R7");
    setMode(5'h11);
    check(1, "R8");
    setMode(5'h13);
    check(1, "R8");
    setMode(5'h17);
    check(1, "R8");
    // R9: return ignored without a saved word, then a real return
    setMode(5'h1D);
    doOp(0, 0, 0, '0, '0, '0, '0, 1);
    check(0, "R9");
    setMode(5'h13);
    doOp(0, 0, 0, '0, '0, '0, '0, 1);
    check(0, "R9");
    check(1, "R9");
    // R2: live control byte with bit 4 clear
    doOp(1, 0, 0, 4'b0001, 32'h0000_0005, '0, '0, 0);
    check(0, "R2");
    // R11: return and write together
    setMode(5'h13);
    doOp(1, 0, 0, 4'hF, 32'h0000_001F, '0, '0, 1);
    check(0, "R11");

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule